// File: doc/BRIEF.md
# Sensitivity map lookup engine

This block decides whether a single-bit configuration upset matters. It takes one upset message: a sector index, a frame index and a bit position within the frame. It then walks a compressed sensitivity map that is stored in an external memory. The walk runs through several levels: the map header, the sector's entry, the sector's encoding block, the frame's information word, the encoding map entry for the bit, the packed tag, and finally the region bitmask that the tag selects. The lookup ends with one of two verdicts. A critical verdict comes with the mask of design regions the bit touches. A non-critical verdict covers unused bits, phantom bits and sectors that have no sensitive bits.

Messages arrive on a valid/ready stream with no buffer. `msg_ready` is high only while the engine is idle. A message is taken on the clock edge where `msg_valid` and `msg_ready` are both high. While a lookup runs, the source stalls, and nothing it drives has any effect. The engine reads the map through a simple read master that works in byte addresses. The master keeps its address and read strobe steady while `mem_waitreq` is high. It takes data only in a cycle where `mem_rvalid` is high, and it has at most one read outstanding.

A verdict stays on the outputs until `clear` is pulsed or the next message is accepted. A map whose identification words are wrong ends the lookup with a sticky `map_error`.

Top module: `smap_lookup`

## Requirements
- R1: `msg_ready` equals not `busy`. A message is accepted only on an edge where `msg_valid` and `msg_ready` are both high. Values driven on the message inputs while `busy` is high are ignored, and the `rep_*` outputs keep the accepted message.
- R2: Map word 0 must hold 0xE445341 in bits [27:0]. Bits [31:28] may hold any value. Any other value in bits [27:0] ends the lookup with `map_error`.
- R3: A sector entry whose third word has a count of zero in bits [23:8] gives a non-critical verdict after exactly 6 map reads: the three header words and the three sector words.
- R4: An encoding-map entry of 0xFFFF gives a non-critical verdict. The entry is the 16-bit half at byte (encoding base + map offset)×4 + map index × map bytes + 2 × bit position, with the low half at the lower byte address.
- R5: A tag value of zero gives a non-critical verdict.
- R6: A nonzero tag t gives a critical verdict. `region_mask` then holds the mask_size bits starting at bit (t−1)×mask_size of the region words, which begin one word after the sector data word. Bits of `region_mask` above mask_size are zero.
- R7: The tag is tag_size bits wide, with tag_size equal to 1, 2, 4 or 8. It starts at bit tag_index×tag_size, counted from bit 0 of word L+1+frame_data_offset×tag_size of the sector data, where L = (mask_size×mask_count+31)/32.
- R8: `busy` rises on the accepting edge. It falls on the same edge that `critical`, `noncritical` or `map_error` rises. `critical` and `noncritical` are never high together.
- R9: A `clear` pulse while idle zeroes `critical`, `noncritical`, `region_mask`, `map_error` and all `rep_*` outputs on the next edge.
- R10: Every read address equals word_index×4 + START_ADDR. While `mem_read` and `mem_waitreq` are both high, `mem_read` and `mem_addr` stay unchanged on the next cycle.
- R11: The lookup ends with `map_error` set, and with neither verdict output high, if the encoding header lacks 0xEEEE in bits [31:16] or the sector data word lacks 0xDDDD in bits [31:16]. `map_error` stays set until `clear`.
- R12: Region mask sizes of 1, 4 and 32 bits are each extracted correctly, including a full 32-bit mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Upset message valid |
| msg_ready | output | 1 | Engine idle, message can be taken |
| msg_sector | input | SEC_W | Sector index of the upset |
| msg_frame | input | FRM_W | Frame index within the sector |
| msg_bitpos | input | BIT_W | Bit position within the frame |
| clear | input | 1 | Clears the verdict, region, echo and error outputs |
| busy | output | 1 | Lookup in progress |
| critical | output | 1 | Upset bit is used by at least one region |
| noncritical | output | 1 | Upset bit is not used by any region |
| region_mask | output | REG_W | Regions touched by a critical bit |
| rep_sector | output | SEC_W | Echo of the accepted sector |
| rep_frame | output | FRM_W | Echo of the accepted frame |
| rep_bitpos | output | BIT_W | Echo of the accepted bit position |
| map_error | output | 1 | Sticky map identification failure |
| mem_addr | output | ADDR_W | Read byte address |
| mem_read | output | 1 | Read strobe |
| mem_waitreq | input | 1 | Memory stalls the pending read |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The main sweep builds a map for every pairing of tag width (1, 2, 4, 8) with region-mask width (1, 4, 32). For each pairing it looks up every bit of four frames. The frames alternate between two encoding maps, one ascending and one reversed, so an error in the map index, the tag offset or the frame offset shows up as a wrong tag. Tag values repeat across all region numbers, including zero, which separates the zero-tag, phantom and critical paths. Each mask width sets its own L, which moves the tag area. Further single runs cover a sector with no sensitive bits, each corrupted identification word, an odd header nibble, and stray inputs while busy. Random wait-request stalls check that the read master holds its address and strobe.

// File: rtl/smap_pkg.sv
package smap_pkg;

  localparam logic [27:0] HDR_SIG = 28'hE445341;
  localparam logic [15:0] ENC_SIG = 16'hEEEE;
  localparam logic [15:0] DAT_SIG = 16'hDDDD;
  localparam logic [15:0] PHANTOM = 16'hFFFF;

  // Order of map reads in one walk
  typedef enum logic [3:0] {
    PH_SIG, PH_RSZ, PH_STAB, PH_SENC, PH_SDAT, PH_SCNT, PH_EHDR,
    PH_FOFF, PH_EOFF, PH_FINFO, PH_EMAP, PH_DHDR, PH_TAG, PH_RMASK
  } phase_e;

  // Values gathered during the walk
  typedef struct packed {
    logic [31:0] stab;
    logic [31:0] enc;
    logic [31:0] dat;
    logic [31:0] foff;
    logic [31:0] eoff;
    logic [15:0] mcnt;
    logic [15:0] mapb;
    logic [15:0] tidx;
    logic [7:0]  tsize;
    logic [7:0]  msize;
    logic [7:0]  tag;
    logic [11:0] midx;
    logic [19:0] fdoff;
  } ctx_t;

  function automatic logic [31:0] take_bits(input logic [31:0] w,
                                            input logic [4:0]  sh,
                                            input logic [7:0]  nb);
    logic [31:0] m;
    m = (nb >= 8'd32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    return (w >> sh) & m;
  endfunction

endpackage

// File: rtl/smap_rd_master.sv
module smap_rd_master #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       word_idx,
  output logic              done,
  output logic [31:0]       data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_read,
  input  logic              mem_waitreq,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid
);

  typedef enum logic [1:0] {RM_IDLE, RM_REQ, RM_WAIT} rm_e;
  rm_e               st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RM_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        RM_IDLE: if (start) begin
          addr_q <= ADDR_W'((word_idx << 2) + START_ADDR);
          st_q   <= RM_REQ;
        end
        RM_REQ:  if (!mem_waitreq) st_q <= RM_WAIT;
        RM_WAIT: if (mem_rvalid) st_q <= RM_IDLE;
        default: st_q <= RM_IDLE;
      endcase
    end
  end

  assign mem_addr = addr_q;
  assign mem_read = (st_q == RM_REQ);
  assign done     = (st_q == RM_WAIT) && mem_rvalid;
  assign data     = mem_rdata;

endmodule

// File: rtl/smap_addr_gen.sv
module smap_addr_gen
  import smap_pkg::*;
#(
  parameter int SEC_W = 8,
  parameter int FRM_W = 12,
  parameter int BIT_W = 12
) (
  input  phase_e         phase,
  input  ctx_t           ctx,
  input  logic [SEC_W-1:0] sector,
  input  logic [FRM_W-1:0] frame,
  input  logic [BIT_W-1:0] bitpos,
  output logic [31:0]    word_idx,
  output logic [4:0]     bit_sh,
  output logic           half_hi
);

  logic [31:0] l_words, tag_bits, rm_bits, ebyte;

  always_comb begin
    l_words  = (32'(ctx.msize) * 32'(ctx.mcnt) + 32'd31) >> 5;
    tag_bits = 32'(ctx.tidx) * 32'(ctx.tsize);
    rm_bits  = (32'(ctx.tag) - 32'd1) * 32'(ctx.msize);
    ebyte    = ((ctx.enc + ctx.eoff) << 2) + 32'(ctx.midx) * 32'(ctx.mapb)
             + (32'(bitpos) << 1);
    word_idx = '0;
    bit_sh   = '0;
    half_hi  = ebyte[1];
    case (phase)
      PH_SIG:   word_idx = 32'd0;
      PH_RSZ:   word_idx = 32'd1;
      PH_STAB:  word_idx = 32'd2;
      PH_SENC:  word_idx = ctx.stab + 32'd3 * 32'(sector);
      PH_SDAT:  word_idx = ctx.stab + 32'd3 * 32'(sector) + 32'd1;
      PH_SCNT:  word_idx = ctx.stab + 32'd3 * 32'(sector) + 32'd2;
      PH_EHDR:  word_idx = ctx.enc;
      PH_FOFF:  word_idx = ctx.enc + 32'd1;
      PH_EOFF:  word_idx = ctx.enc + 32'd2;
      PH_FINFO: word_idx = ctx.enc + ctx.foff + 32'(frame);
      PH_EMAP:  word_idx = ebyte >> 2;
      PH_DHDR:  word_idx = ctx.dat;
      PH_TAG: begin
        word_idx = ctx.dat + l_words + 32'd1 + 32'(ctx.fdoff) * 32'(ctx.tsize)
                 + (tag_bits >> 5);
        bit_sh   = tag_bits[4:0];
      end
      PH_RMASK: begin
        word_idx = ctx.dat + 32'd1 + (rm_bits >> 5);
        bit_sh   = rm_bits[4:0];
      end
      default:  word_idx = 32'd0;
    endcase
  end

endmodule

// File: rtl/smap_lookup.sv
module smap_lookup
  import smap_pkg::*;
#(
  parameter int          SEC_W      = 8,
  parameter int          FRM_W      = 12,
  parameter int          BIT_W      = 12,
  parameter int          REG_W      = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [SEC_W-1:0]  msg_sector,
  input  logic [FRM_W-1:0]  msg_frame,
  input  logic [BIT_W-1:0]  msg_bitpos,
  input  logic              clear,
  output logic              busy,
  output logic              critical,
  output logic              noncritical,
  output logic [REG_W-1:0]  region_mask,
  output logic [SEC_W-1:0]  rep_sector,
  output logic [FRM_W-1:0]  rep_frame,
  output logic [BIT_W-1:0]  rep_bitpos,
  output logic              map_error,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_read,
  input  logic              mem_waitreq,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e              st_q;
  phase_e           phase_q;
  ctx_t             ctx_q;
  logic [SEC_W-1:0] cur_sec_q;
  logic [FRM_W-1:0] cur_frm_q;
  logic [BIT_W-1:0] cur_bit_q;
  logic             crit_q, nc_q, err_q;
  logic [REG_W-1:0] reg_q;

  logic        rd_start, rd_done, half_hi;
  logic [31:0] rd_data, word_idx, field;
  logic [4:0]  bit_sh;
  logic [15:0] half_w;

  smap_addr_gen #(.SEC_W(SEC_W), .FRM_W(FRM_W), .BIT_W(BIT_W)) agen_i (
    .phase(phase_q), .ctx(ctx_q), .sector(cur_sec_q), .frame(cur_frm_q),
    .bitpos(cur_bit_q), .word_idx(word_idx), .bit_sh(bit_sh), .half_hi(half_hi)
  );

  smap_rd_master #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) rdm_i (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .word_idx(word_idx),
    .done(rd_done), .data(rd_data), .mem_addr(mem_addr), .mem_read(mem_read),
    .mem_waitreq(mem_waitreq), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  assign rd_start = (st_q == ST_ISSUE);
  assign half_w   = half_hi ? rd_data[31:16] : rd_data[15:0];
  assign field    = take_bits(rd_data, bit_sh,
                              (phase_q == PH_TAG) ? ctx_q.tsize : ctx_q.msize);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      phase_q   <= PH_SIG;
      ctx_q     <= '0;
      cur_sec_q <= '0;
      cur_frm_q <= '0;
      cur_bit_q <= '0;
      crit_q    <= 1'b0;
      nc_q      <= 1'b0;
      err_q     <= 1'b0;
      reg_q     <= '0;
      rep_sector <= '0;
      rep_frame  <= '0;
      rep_bitpos <= '0;
    end else begin
      if (clear) begin
        crit_q     <= 1'b0;
        nc_q       <= 1'b0;
        err_q      <= 1'b0;
        reg_q      <= '0;
        rep_sector <= '0;
        rep_frame  <= '0;
        rep_bitpos <= '0;
      end
      case (st_q)
        ST_IDLE: if (msg_valid) begin
          cur_sec_q  <= msg_sector;
          cur_frm_q  <= msg_frame;
          cur_bit_q  <= msg_bitpos;
          rep_sector <= msg_sector;
          rep_frame  <= msg_frame;
          rep_bitpos <= msg_bitpos;
          crit_q     <= 1'b0;
          nc_q       <= 1'b0;
          reg_q      <= '0;
          phase_q    <= PH_SIG;
          st_q       <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (rd_done) begin
          st_q <= ST_ISSUE;
          case (phase_q)
            PH_SIG: begin
              if (rd_data[27:0] != HDR_SIG) begin
                err_q <= 1'b1;
                st_q  <= ST_IDLE;
              end else phase_q <= PH_RSZ;
            end
            PH_RSZ:  begin ctx_q.msize <= rd_data[7:0]; phase_q <= PH_STAB; end
            PH_STAB: begin ctx_q.stab  <= rd_data;      phase_q <= PH_SENC; end
            PH_SENC: begin ctx_q.enc   <= rd_data;      phase_q <= PH_SDAT; end
            PH_SDAT: begin ctx_q.dat   <= rd_data;      phase_q <= PH_SCNT; end
            PH_SCNT: begin
              ctx_q.mcnt  <= rd_data[23:8];
              ctx_q.tsize <= rd_data[7:0];
              if (rd_data[23:8] == 16'd0) begin
                nc_q <= 1'b1;
                st_q <= ST_IDLE;
              end else phase_q <= PH_EHDR;
            end
            PH_EHDR: begin
              if (rd_data[31:16] != ENC_SIG) begin
                err_q <= 1'b1;
                st_q  <= ST_IDLE;
              end else begin
                ctx_q.mapb <= rd_data[15:0];
                phase_q    <= PH_FOFF;
              end
            end
            PH_FOFF: begin ctx_q.foff <= rd_data; phase_q <= PH_EOFF; end
            PH_EOFF: begin ctx_q.eoff <= rd_data; phase_q <= PH_FINFO; end
            PH_FINFO: begin
              ctx_q.midx  <= rd_data[31:20];
              ctx_q.fdoff <= rd_data[19:0];
              phase_q     <= PH_EMAP;
            end
            PH_EMAP: begin
              ctx_q.tidx <= half_w;
              if (half_w == PHANTOM) begin
                nc_q <= 1'b1;
                st_q <= ST_IDLE;
              end else phase_q <= PH_DHDR;
            end
            PH_DHDR: begin
              if (rd_data[31:16] != DAT_SIG) begin
                err_q <= 1'b1;
                st_q  <= ST_IDLE;
              end else phase_q <= PH_TAG;
            end
            PH_TAG: begin
              ctx_q.tag <= field[7:0];
              if (field[7:0] == 8'd0) begin
                nc_q <= 1'b1;
                st_q <= ST_IDLE;
              end else phase_q <= PH_RMASK;
            end
            PH_RMASK: begin
              reg_q  <= REG_W'(field);
              crit_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign msg_ready   = (st_q == ST_IDLE);
  assign critical    = crit_q;
  assign noncritical = nc_q;
  assign region_mask = reg_q;
  assign map_error   = err_q;

endmodule

// File: rtl/smap_lookup_chk.sv
module smap_lookup_chk #(
  parameter int          REG_W      = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_ready,
  input logic              clear,
  input logic              busy,
  input logic              critical,
  input logic              noncritical,
  input logic [REG_W-1:0]  region_mask,
  input logic              map_error,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_read,
  input logic              mem_waitreq
);

  // R1
  ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !msg_ready);

  // R8
  busy_end_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (critical || noncritical || map_error));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(critical && noncritical));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !busy) |=> (!critical && !noncritical && region_mask == '0 && !map_error));

  // R10
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && mem_waitreq) |=> (mem_read && $stable(mem_addr)));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |-> (mem_addr[1:0] == START_ADDR[1:0]));

  // R11
  error_no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(map_error) |-> (!busy && !critical && !noncritical));

endmodule

bind smap_lookup smap_lookup_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .clear(clear), .busy(busy),
  .critical(critical), .noncritical(noncritical), .region_mask(region_mask),
  .map_error(map_error), .mem_addr(mem_addr), .mem_read(mem_read),
  .mem_waitreq(mem_waitreq)
);

// File: tb/smap_lookup_tb.sv
module smap_lookup_tb_top;

  localparam logic [31:0] START = 32'h0000_1000;
  localparam int MEMW = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [7:0]  msg_sector = '0;
  logic [11:0] msg_frame = '0;
  logic [11:0] msg_bitpos = '0;
  logic        clear = 1'b0;
  logic        busy, critical, noncritical, map_error;
  logic [31:0] region_mask;
  logic [7:0]  rep_sector;
  logic [11:0] rep_frame, rep_bitpos;
  logic [31:0] mem_addr;
  logic        mem_read;
  logic        mem_waitreq = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  logic [31:0] mem [0:MEMW-1];

  int n_tests = 0;
  int n_fail  = 0;
  int reads   = 0;
  int addr_bad = 0;
  int hold_bad = 0;
  int hold_seen = 0;
  int ready_bad = 0;
  longint cycles = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  smap_lookup #(.START_ADDR(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_sector(msg_sector), .msg_frame(msg_frame), .msg_bitpos(msg_bitpos),
    .clear(clear), .busy(busy), .critical(critical), .noncritical(noncritical),
    .region_mask(region_mask), .rep_sector(rep_sector), .rep_frame(rep_frame),
    .rep_bitpos(rep_bitpos), .map_error(map_error), .mem_addr(mem_addr),
    .mem_read(mem_read), .mem_waitreq(mem_waitreq), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid)
  );

  // memory model: stalls from an LFSR, two-edge read latency
  logic [7:0]  lfsr = 8'hA5;
  logic        v1 = 1'b0;
  logic [31:0] d1 = '0;
  logic [31:0] widx;
  assign widx = (mem_addr - START) >> 2;

  always @(posedge clk) begin
    lfsr        <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_waitreq <= lfsr[0] & lfsr[2];
    v1          <= mem_read && !mem_waitreq;
    d1          <= mem[widx[8:0]];
    mem_rvalid  <= v1;
    mem_rdata   <= d1;
  end

  // monitor away from the edge
  logic        p_rw = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (p_rw) begin
        hold_seen <= hold_seen + 1;
        if (!(mem_read && mem_addr == p_addr)) hold_bad <= hold_bad + 1;
      end
      if (mem_read && !mem_waitreq) begin
        reads <= reads + 1;
        if (mem_addr[1:0] != 2'b00 || mem_addr < START || widx >= MEMW)
          addr_bad <= addr_bad + 1;
      end
      if (busy && msg_ready) ready_bad <= ready_bad + 1;
    end
    p_rw   <= rst_n && mem_read && mem_waitreq;
    p_addr <= mem_addr;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- bench-side map model ----
  int ts_c, ms_c, mc_c, l_c;

  function automatic int truth_tag(input int f, input int b);
    return (f * 5 + b * 3) % (mc_c + 1);
  endfunction

  function automatic logic [31:0] rmask(input int m);
    logic [31:0] v;
    logic [31:0] msk;
    v   = (32'(m) * 32'h9E3779B1) >> 3;
    msk = (ms_c >= 32) ? 32'hFFFF_FFFF : ((32'd1 << ms_c) - 32'd1);
    return v & msk;
  endfunction

  task automatic build_map(input int ts, input int ms, input logic [3:0] nib);
    ts_c = ts;
    ms_c = ms;
    mc_c = ((1 << ts) - 1 < 6) ? (1 << ts) - 1 : 6;
    l_c  = (ms * mc_c + 31) / 32;
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    mem[0] = {nib, 28'hE445341};
    mem[1] = 32'(ms);
    mem[2] = 32'd16;
    for (int s = 0; s < 4; s++) begin
      mem[16 + 3 * s]     = 32'd40;
      mem[16 + 3 * s + 1] = 32'd64;
      mem[16 + 3 * s + 2] = ((s == 3) ? 32'd0 : 32'(mc_c) << 8) | 32'(ts);
    end
    mem[40] = {16'hEEEE, 16'd32};
    mem[41] = 32'd3;
    mem[42] = 32'd8;
    for (int f = 0; f < 4; f++) mem[43 + f] = (32'(f % 2) << 20) | 32'(f * 4);
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 16; b++) begin
        logic [15:0] e;
        int byte_a;
        e = (b == 15) ? 16'hFFFF : ((m == 0) ? 16'(b) : 16'(14 - b));
        byte_a = 48 * 4 + m * 32 + b * 2;
        if (byte_a % 4 == 2) mem[byte_a / 4][31:16] = e;
        else                 mem[byte_a / 4][15:0]  = e;
      end
    mem[64] = {16'hDDDD, 16'h0000};
    for (int m = 1; m <= mc_c; m++) begin
      int bp;
      bp = (m - 1) * ms;
      mem[65 + bp / 32] = mem[65 + bp / 32] | (rmask(m) << (bp % 32));
    end
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 15; i++) begin
        int b, bp, tb;
        b  = (f % 2 == 0) ? i : 14 - i;
        bp = i * ts;
        tb = 64 + l_c + 1 + f * 4 * ts;
        mem[tb + bp / 32] = mem[tb + bp / 32] | (32'(truth_tag(f, b)) << (bp % 32));
      end
  endtask

  task automatic run_lookup(input int s, input int f, input int b);
    @(negedge clk);
    msg_valid  = 1'b1;
    msg_sector = 8'(s);
    msg_frame  = 12'(f);
    msg_bitpos = 12'(b);
    reads      = 0;
    @(negedge clk);
    msg_valid = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // result check: busy has just fallen at the edge before this negedge
  task automatic check_normal(input int s, input int f, input int b);
    int t;
    chk(critical || noncritical, "R8 verdict with busy fall", {critical, noncritical}, 1);
    if (b == 15) begin
      chk(noncritical && !critical, "R4 phantom bit", {critical, noncritical}, 1);
    end else begin
      t = truth_tag(f, b);
      if (t == 0)
        chk(noncritical && !critical, "R5 zero tag", {critical, noncritical}, 1);
      else
        chk(critical && region_mask == rmask(t),
            (ms_c == 32) ? "R12 R6 R7 region of tag" : "R6 R7 region of tag",
            region_mask, rmask(t));
    end
    chk(rep_sector == 8'(s) && rep_frame == 12'(f) && rep_bitpos == 12'(b),
        "R1 echo", rep_bitpos, b);
  endtask

  // watchdog
  initial begin
    wait (cycles > 190000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ts_l[4];
    int ms_l[3];
    ts_l = '{1, 2, 4, 8};
    ms_l = '{1, 4, 32};
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R1 R9
    chk(!busy && msg_ready, "R1 reset ready", {busy, msg_ready}, 1);
    chk(!critical && !noncritical && region_mask == 0 && !map_error, "R9 reset outputs",
        {critical, noncritical, map_error}, 0);

    // main sweep R4 R5 R6 R7 R12
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 3; c++) begin
        build_map(ts_l[a], ms_l[c], 4'(a * 3 + c));
        for (int f = 0; f < 4; f++)
          for (int b = 0; b < 16; b++) begin
            run_lookup((f + b) % 3, f, b);
            check_normal((f + b) % 3, f, b);
          end
      end

    // R3 empty sector
    build_map(4, 8, 4'hF);
    run_lookup(3, 1, 2);
    chk(noncritical && !critical, "R3 empty sector verdict", {critical, noncritical}, 1);
    chk(reads == 6, "R3 read count", reads, 6);

    // R2 top nibble ignored (nibble F above) and R1 inputs ignored while busy
    @(negedge clk);
    msg_valid = 1'b1; msg_sector = 8'd0; msg_frame = 12'd0; msg_bitpos = 12'd1;
    @(negedge clk);
    msg_sector = 8'd2; msg_frame = 12'd3; msg_bitpos = 12'd7;
    for (int k = 0; k < 3000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    msg_valid = 1'b0;
    chk(rep_sector == 8'd0 && rep_frame == 12'd0 && rep_bitpos == 12'd1,
        "R1 stray input while busy", rep_bitpos, 1);
    chk(!map_error && (critical || noncritical), "R2 nibble ignored", map_error, 0);
    chk(ready_bad == 0, "R1 ready low while busy", ready_bad, 0);

    // R9 clear after a critical verdict (f0 b1 tag 3 of 6)
    run_lookup(0, 0, 1);
    chk(critical, "R6 critical before clear", critical, 1);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk(!critical && !noncritical && region_mask == 0 && rep_sector == 0 &&
        rep_frame == 0 && rep_bitpos == 0, "R9 clear", region_mask, 0);

    // R2 bad header
    mem[0] = 32'h0E445340;
    run_lookup(0, 0, 1);
    chk(map_error && !critical && !noncritical && !busy, "R2 header mismatch",
        {map_error, critical, noncritical}, 4);
    repeat (3) @(negedge clk);
    chk(map_error, "R11 error sticky", map_error, 1);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk(!map_error, "R9 clear error", map_error, 0);
    mem[0] = 32'h5E445341;

    // R11 encoding header mismatch
    mem[40] = {16'hEEEF, 16'd32};
    run_lookup(0, 0, 1);
    chk(map_error && !critical && !noncritical, "R11 encoding mismatch",
        {map_error, critical, noncritical}, 4);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    mem[40] = {16'hEEEE, 16'd32};

    // R11 data header mismatch
    mem[64] = {16'hDDDC, 16'h0000};
    run_lookup(0, 0, 1);
    chk(map_error && !critical && !noncritical, "R11 data mismatch",
        {map_error, critical, noncritical}, 4);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    mem[64] = {16'hDDDD, 16'h0000};

    // recovery after errors
    run_lookup(0, 0, 1);
    chk(critical && !map_error && region_mask == rmask(3), "R6 after recovery",
        region_mask, rmask(3));

    // R10 address and hold behaviour
    chk(addr_bad == 0, "R10 byte address", addr_bad, 0);
    chk(hold_bad == 0 && hold_seen > 0, "R10 hold under wait", hold_bad, 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule